// File: doc/BRIEF.md
# Write-Enable Gated Program and Erase Command Decoder

This block decodes the modifying commands of a serial flash command stream. Bits arrive MSB first on a one-bit input, qualified by a strobe, while an active-low select is held low. The decoder tracks a write-enable latch and accepts byte-program, three sizes of block erase and whole-array erase. Each modifying command is checked against the latch and a protection address range. Nothing is acted upon until the select returns high, and then only when the frame length matches the command exactly.

An accepted modification updates an internal sampled image of the array and starts a self-timed busy period counted in system clocks. The sampled image keeps one byte for every combination of six address bits: the two bits just above the 64 KB boundary, the 32 KB boundary bit, the 4 KB boundary bit and address bits 1..0. Program performs a bitwise AND into that image, and erase writes FFh into it. A status-read command streams the status byte on the serial output for as long as the select stays low, including while busy. A peek port exposes the sampled image so that the array contents can be observed.

Top module: `wgate_mod_decoder`

## Requirements
- R1: A frame of exactly 8 bits carrying opcode 06h sets the write-enable latch, and 04h clears it. The latch is visible on `wel` and in status bit 1, and it changes on the clock edge that first sees `cs_n` high after the frame.
- R2: Program and erase frames arriving while the latch is clear are ignored: `busy` stays low and the image is unchanged.
- R3: Opcode 02h with 24 address bits and 8 data bits (40 bits in total) replaces the addressed image byte with old AND data. The write happens only when the address has zeros outside the six sampled bits.
- R4: Opcodes 20h, 52h and D8h (8 opcode bits plus 24 address bits, 32 in total) set to FFh every image byte whose address agrees with the target on bits 12 and up, 15 and up, and 16 and up respectively.
- R5: Opcodes 60h and C7h in an 8-bit frame set every image byte to FFh.
- R6: Protection is active when `prot_lo` <= `prot_hi`, and it covers that inclusive range. A program that lands inside the range, an erase whose region overlaps it, or any whole-array erase while protection is active, is ignored: there is no busy period and the latch keeps its value.
- R7: A frame whose bit count differs from the length its opcode requires has no effect.
- R8: An accepted program or erase raises `busy` (status bit 0) on the commit edge, and `busy` stays high for exactly BUSY_CYC clocks.
- R9: The write-enable latch clears on the same edge on which `busy` falls.
- R10: While `busy` is high, every frame is ignored apart from status read.
- R11: After the 8 bits of opcode 05h, `so` presents status bit 7. Each further bit strobe moves `so` to the next lower bit, and the sequence wraps every 8 bits. The status byte is {6'b0, latch, busy}. `so` is 0 whenever the select is high or no status read is in progress.
- R12: `peek_data` shows the image byte at index {A17,A16,A15,A12,A1,A0} = `peek_idx`. Every byte reads FFh after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select; its rising edge commits the frame |
| bit_vld | input | 1 | Strobe: sample `bit_in` on this clock |
| bit_in | input | 1 | Serial command bit, MSB first |
| prot_lo | input | 24 | Lowest protected address |
| prot_hi | input | 24 | Highest protected address |
| peek_idx | input | 6 | Index of the image byte to observe |
| so | output | 1 | Serial status output |
| busy | output | 1 | Self-timed operation in progress |
| wel | output | 1 | Write-enable latch |
| peek_data | output | 8 | Image byte at `peek_idx` |

## Verification
All results follow the first clock edge that sees `cs_n` high after a frame. `wel`, `busy` and the image byte all change on that edge, so the bench releases the select on a falling edge and samples at the next falling edge. The busy period is measured by counting the falling edges on which `busy` is high, and the latch is sampled on the first falling edge at which `busy` is low. The status output is registered from the bit counter, so each `so` value is checked half a clock after the strobe that produced it.

// File: rtl/wgate_pkg.sv
package wgate_pkg;
  localparam int ADDR_W = 24;
  localparam int IDX_W  = 6;
  localparam int DEPTH  = 1 << IDX_W;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_ER4K  = 8'h20;
  localparam logic [7:0] OP_ER32K = 8'h52;
  localparam logic [7:0] OP_ER64K = 8'hD8;
  localparam logic [7:0] OP_CHIPA = 8'h60;
  localparam logic [7:0] OP_CHIPB = 8'hC7;
  localparam logic [7:0] OP_STAT  = 8'h05;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_SETWE, ACT_CLRWE, ACT_PROG, ACT_ERASE, ACT_CHIP
  } act_e;

  // Address of the sampled byte at index i (all other bits zero)
  function automatic logic [ADDR_W-1:0] sample_addr(input logic [IDX_W-1:0] i,
      input int sec, input int b32, input int b64);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[b64+1] = i[5];
    a[b64]   = i[4];
    a[b32]   = i[3];
    a[sec]   = i[2];
    a[1:0]   = i[1:0];
    return a;
  endfunction

  function automatic logic [IDX_W-1:0] sample_idx(input logic [ADDR_W-1:0] a,
      input int sec, input int b32, input int b64);
    return {a[b64+1], a[b64], a[b32], a[sec], a[1], a[0]};
  endfunction

  function automatic logic [ADDR_W-1:0] region_mask(input logic [4:0] lsb);
    return (ADDR_W'(1) << lsb) - ADDR_W'(1);
  endfunction

  // Inclusive overlap of [b,t] with [lo,hi]; protection off when lo > hi
  function automatic logic range_hit(input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] t,
      input logic [ADDR_W-1:0] lo, input logic [ADDR_W-1:0] hi);
    return (lo <= hi) && (b <= hi) && (t >= lo);
  endfunction
endpackage

// File: rtl/wgate_bit_rx.sv
module wgate_bit_rx #(
  parameter int FRAME_W = 40,
  localparam int CNT_W = $clog2(FRAME_W + 2) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               bit_vld,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits,
  output logic [2:0]         phase,
  output logic [7:0]         opcode,
  output logic               op_ok,
  output logic               cs_rise
);
  localparam logic [CNT_W-1:0] SAT = '1;
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      frame  <= '0;
      nbits  <= '0;
      phase  <= '0;
      opcode <= '0;
      op_ok  <= 1'b0;
    end else begin
      cs_q <= cs_n;
      if (cs_n) begin
        nbits <= '0;
        phase <= '0;
        op_ok <= 1'b0;
      end else if (bit_vld) begin
        frame <= {frame[FRAME_W-2:0], bit_in};
        phase <= phase + 3'd1;
        if (nbits != SAT) nbits <= nbits + 1'b1;
        if (nbits == CNT_W'(7)) begin
          opcode <= {frame[6:0], bit_in};
          op_ok  <= 1'b1;
        end
      end
    end
  end

  assign cs_rise = cs_n & ~cs_q;
endmodule

// File: rtl/wgate_busy_timer.sv
module wgate_busy_timer #(
  parameter int BUSY_CYC = 64,
  localparam int CW = $clog2(BUSY_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= CW'(BUSY_CYC);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));
endmodule

// File: rtl/wgate_image.sv
module wgate_image
  import wgate_pkg::*;
#(
  parameter int SEC_LSB = 12,
  parameter int B32_LSB = 15,
  parameter int B64_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_go,
  input  logic              erase_go,
  input  logic              chip_go,
  input  logic [4:0]        erase_lsb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [IDX_W-1:0]  peek_idx,
  output logic [7:0]        peek_data
);
  logic [IDX_W-1:0]   p_idx;
  logic               p_exact;
  logic [DEPTH*8-1:0] flat;

  assign p_idx   = sample_idx(addr, SEC_LSB, B32_LSB, B64_LSB);
  assign p_exact = (sample_addr(p_idx, SEC_LSB, B32_LSB, B64_LSB) == addr);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [ADDR_W-1:0] EA = sample_addr(IDX_W'(g), SEC_LSB, B32_LSB, B64_LSB);
    logic [7:0] q;
    logic       er_hit;
    logic       pg_hit;
    assign er_hit = chip_go || (erase_go && ((EA >> erase_lsb) == (addr >> erase_lsb)));
    assign pg_hit = prog_go && p_exact && (p_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 8'hFF;
      else if (er_hit) q <= 8'hFF;
      else if (pg_hit) q <= q & wdata;
    end
    assign flat[g*8 +: 8] = q;
  end

  assign peek_data = flat[peek_idx*8 +: 8];
endmodule

// File: rtl/wgate_mod_decoder.sv
module wgate_mod_decoder
  import wgate_pkg::*;
#(
  parameter int BUSY_CYC = 64,
  parameter int SEC_LSB  = 12,
  parameter int B32_LSB  = 15,
  parameter int B64_LSB  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic [ADDR_W-1:0] prot_lo,
  input  logic [ADDR_W-1:0] prot_hi,
  input  logic [IDX_W-1:0]  peek_idx,
  output logic              so,
  output logic              busy,
  output logic              wel,
  output logic [7:0]        peek_data
);
  localparam int FRAME_W = 40;
  localparam int CNT_W   = $clog2(FRAME_W + 2) + 1;

  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  logic [2:0]         phase;
  logic [7:0]         opcode;
  logic               op_ok, cs_rise, done;
  act_e               act;
  logic [4:0]         er_lsb;
  logic [ADDR_W-1:0]  addr;
  logic               prot_hit, commit, mod_go, accept;
  logic               set_we, clr_we;
  logic [7:0]         status;

  wgate_bit_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk, .rst_n, .cs_n, .bit_vld, .bit_in,
    .frame, .nbits, .phase, .opcode, .op_ok, .cs_rise
  );

  // Decode: opcode plus exact frame length
  always_comb begin
    act    = ACT_NONE;
    er_lsb = 5'(SEC_LSB);
    if (op_ok) begin
      unique case (opcode)
        OP_WREN:  if (nbits == CNT_W'(8))  act = ACT_SETWE;
        OP_WRDI:  if (nbits == CNT_W'(8))  act = ACT_CLRWE;
        OP_PROG:  if (nbits == CNT_W'(40)) act = ACT_PROG;
        OP_ER4K:  if (nbits == CNT_W'(32)) act = ACT_ERASE;
        OP_ER32K: begin er_lsb = 5'(B32_LSB); if (nbits == CNT_W'(32)) act = ACT_ERASE; end
        OP_ER64K: begin er_lsb = 5'(B64_LSB); if (nbits == CNT_W'(32)) act = ACT_ERASE; end
        OP_CHIPA, OP_CHIPB: if (nbits == CNT_W'(8)) act = ACT_CHIP;
        default: act = ACT_NONE;
      endcase
    end
  end

  assign addr = (act == ACT_PROG) ? frame[31:8] : frame[23:0];

  always_comb begin
    unique case (act)
      ACT_PROG:  prot_hit = range_hit(addr, addr, prot_lo, prot_hi);
      ACT_ERASE: prot_hit = range_hit(addr & ~region_mask(er_lsb),
                                      addr | region_mask(er_lsb), prot_lo, prot_hi);
      ACT_CHIP:  prot_hit = (prot_lo <= prot_hi);
      default:   prot_hit = 1'b0;
    endcase
  end

  assign commit = cs_rise && !busy;
  assign mod_go = commit && wel && !prot_hit &&
                  (act == ACT_PROG || act == ACT_ERASE || act == ACT_CHIP);
  assign set_we = commit && (act == ACT_SETWE);
  assign clr_we = commit && (act == ACT_CLRWE);
  assign accept = mod_go || set_we || clr_we;

  wgate_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_tmr (
    .clk, .rst_n, .start(mod_go), .busy, .done
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wel <= 1'b0;
    else if (set_we)         wel <= 1'b1;
    else if (clr_we || done) wel <= 1'b0;
  end

  wgate_image #(.SEC_LSB(SEC_LSB), .B32_LSB(B32_LSB), .B64_LSB(B64_LSB)) u_img (
    .clk, .rst_n,
    .prog_go (mod_go && act == ACT_PROG),
    .erase_go(mod_go && act == ACT_ERASE),
    .chip_go (mod_go && act == ACT_CHIP),
    .erase_lsb(er_lsb), .addr, .wdata(frame[7:0]),
    .peek_idx, .peek_data
  );

  assign status = {6'b0, wel, busy};
  assign so = (!cs_n && op_ok && opcode == OP_STAT) ? status[3'd7 - phase] : 1'b0;
endmodule

// File: rtl/wgate_mod_chk.sv
module wgate_mod_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       so,
  input logic       busy,
  input logic       wel,
  input logic [5:0] peek_idx,
  input logic [7:0] peek_data,
  input logic       mod_go,
  input logic       accept,
  input logic       done
);
  p_needs_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mod_go |-> wel);
  p_busy_after_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mod_go |=> busy);
  p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mod_go));
  p_wel_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!wel && !busy));
  p_quiet_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);
  p_image_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_go |=> (peek_data == $past(peek_data)) || (peek_idx != $past(peek_idx)));
  p_so_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !so);
endmodule

bind wgate_mod_decoder wgate_mod_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so(so), .busy(busy), .wel(wel),
  .peek_idx(peek_idx), .peek_data(peek_data),
  .mod_go(mod_go), .accept(accept), .done(done)
);

// File: tb/tb_wgate_mod_decoder.sv
module tb_wgate_mod_decoder;
  localparam int BUSY = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, bit_vld = 1'b0, bit_in = 1'b0;
  logic [23:0] prot_lo = 24'hFFFFFF, prot_hi = 24'h000000;
  logic [5:0]  peek_idx = '0;
  logic        so, busy, wel;
  logic [7:0]  peek_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  wgate_mod_decoder #(.BUSY_CYC(BUSY)) dut (
    .clk, .rst_n, .cs_n, .bit_vld, .bit_in, .prot_lo, .prot_hi,
    .peek_idx, .so, .busy, .wel, .peek_data
  );

  typedef struct packed {
    logic [39:0] cmd;
    logic [5:0]  len;
    logic        wren;
    logic        exp_busy;
    logic [5:0]  idx;
    logic [7:0]  exp;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{40'h02000001A5, 6'd40, 1'b1, 1'b1, 6'd1,  8'hA5},
    '{40'h020000013C, 6'd40, 1'b1, 1'b1, 6'd1,  8'h24},
    '{40'h0200000200, 6'd40, 1'b0, 1'b0, 6'd2,  8'hFF},
    '{40'h020010020F, 6'd40, 1'b1, 1'b1, 6'd6,  8'h0F},
    '{40'h0200010300, 6'd40, 1'b1, 1'b1, 6'd3,  8'hFF},
    '{40'h0200800011, 6'd40, 1'b1, 1'b1, 6'd8,  8'h11},
    '{40'h5200812300, 6'd32, 1'b1, 1'b1, 6'd8,  8'hFF},
    '{40'h5200000000, 6'd31, 1'b1, 1'b0, 6'd1,  8'h24},
    '{40'h20001FFF00, 6'd32, 1'b1, 1'b1, 6'd6,  8'hFF},
    '{40'hD800ABCD00, 6'd32, 1'b1, 1'b1, 6'd1,  8'hFF},
    '{40'h0203000042, 6'd40, 1'b1, 1'b1, 6'd48, 8'h42},
    '{40'hD802000000, 6'd32, 1'b1, 1'b1, 6'd48, 8'h42},
    '{40'hC700000000, 6'd8,  1'b1, 1'b1, 6'd48, 8'hFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [39:0] v, input int n);
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      bit_vld = 1'b1;
      bit_in  = v[39-i];
      @(negedge clk);
    end
    bit_vld = 1'b0;
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  int c;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check("R12 reset busy", busy, 0);
    check("R12 reset wel", wel, 0);
    check("R12 reset so", so, 0);
    peek_idx = 6'd0;
    #1 check("R12 reset image", peek_data, 8'hFF);

    // R1 set and clear
    frame(40'h0600000000, 8);
    check("R1 set latch", wel, 1);
    check("R1 no busy", busy, 0);
    frame(40'h0400000000, 8);
    check("R1 clear latch", wel, 0);

    // R7 wrong length
    frame(40'h0600000000, 9);
    check("R7 9-bit enable ignored", wel, 0);

    // Table walk: R2 R3 R4 R5 R7 R8 R9
    foreach (VECS[k]) begin
      peek_idx = VECS[k].idx;
      if (VECS[k].wren) frame(40'h0600000000, 8);
      frame(VECS[k].cmd, int'(VECS[k].len));
      check($sformatf("R2/R7/R8 vector %0d busy", k), busy, VECS[k].exp_busy);
      if (VECS[k].exp_busy) begin
        wait_idle(c);
        check($sformatf("R8 vector %0d duration", k), c, BUSY);
        check($sformatf("R9 vector %0d latch", k), wel, 0);
      end
      check($sformatf("R3/R4/R5 vector %0d image", k), peek_data, VECS[k].exp);
    end
    frame(40'h0400000000, 8);

    // R11 status stream while busy, R10 ignored commands
    peek_idx = 6'd3;
    frame(40'h0600000000, 8);
    frame(40'h0200000200, 40);
    check("R8 busy started", busy, 1);
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      bit_vld = 1'b1; bit_in = (8'h05 >> (7 - i)) & 1'b1;
      @(negedge clk);
    end
    for (int i = 0; i < 16; i++) begin
      check($sformatf("R11 status bit %0d", i), so, ((8'h03 >> (7 - (i % 8))) & 1));
      bit_vld = 1'b1; bit_in = 1'b0;
      @(negedge clk);
    end
    bit_vld = 1'b0; cs_n = 1'b1;
    @(negedge clk);
    check("R11 so idle", so, 0);
    frame(40'h0400000000, 8);
    check("R10 disable ignored while busy", wel, 1);
    frame(40'h0200000300, 40);
    wait_idle(c);
    check("R10 program ignored while busy", peek_data, 8'hFF);
    peek_idx = 6'd2;
    #1 check("R3 program landed", peek_data, 8'h00);

    // R6 protection 0..FFF
    prot_lo = 24'h000000; prot_hi = 24'h000FFF;
    peek_idx = 6'd1;
    frame(40'h0600000000, 8);
    frame(40'h0200000100, 40);
    check("R6 protected program no busy", busy, 0);
    check("R6 latch kept", wel, 1);
    check("R6 protected image", peek_data, 8'hFF);
    frame(40'hD800000000, 32);
    check("R6 overlapping erase ignored", busy, 0);
    frame(40'h6000000000, 8);
    check("R6 chip erase ignored", busy, 0);
    frame(40'h2000100000, 32);
    check("R6 outside sector accepted", busy, 1);
    wait_idle(c);
    prot_lo = 24'hFFFFFF; prot_hi = 24'h000000;
    frame(40'h0600000000, 8);
    frame(40'h0200000100, 40);
    wait_idle(c);
    check("R6 unprotected program", peek_data, 8'h00);

    // R5 chip erase with 60h
    frame(40'h0600000000, 8);
    frame(40'h6000000000, 8);
    check("R5 busy", busy, 1);
    wait_idle(c);
    check("R5 image erased", peek_data, 8'hFF);
    peek_idx = 6'd2;
    #1 check("R5 image erased idx2", peek_data, 8'hFF);

    // R2 erase without latch
    frame(40'h0200000200, 40);
    frame(40'h0600000000, 8);
    frame(40'h0200000200, 40);
    wait_idle(c);
    check("R2 program after enable", peek_data, 8'h00);
    frame(40'h2000000000, 32);
    check("R2 erase without latch no busy", busy, 0);
    check("R2 erase without latch image", peek_data, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule